// File: doc/BRIEF.md
# Peak Power Overload/Relax Sequencer

This block controls a charger's two-level input current limit while peak power mode is active. When an enabled trigger occurs, the sequencer raises a select line that picks the higher current limit for a programmed overload time. It then holds the lower limit for the rest of a programmed cycle time, which is the relax phase, and returns to idle. One trigger is an input-current-overshoot flag and the other is a system-voltage-undershoot flag. The two comparator flags may be asynchronous and are synchronized inside the block. All timing is counted in pulses of a one-millisecond tick input.

Software sees one 8-bit configuration word through a plain write strobe and a continuously driven read word. The word holds the two trigger enables, the two timing codes and the two phase status bits. Writing 0 to a status bit forces the sequencer out of that phase. Removing the adapter, or clearing both enables, drops the sequencer to idle. There is no streaming data path: every pin is a plain control or status level. A write therefore takes effect without any handshake or back-pressure.

Top module: `surge_cycle_ctrl`

## Requirements
- R1: After reset, the select output and both status outputs are 0 and the read word is 8'h08 (overload code 00, cycle code 10, both enables 0).
- R2: Overload time code (word bits [1:0]) maps 00=1, 01=2, 10=10, 11=20 ticks. An enabled trigger starts the overload phase, which lasts exactly that many ticks. The select output is 1 only during the overload phase.
- R3: Cycle time code (bits [3:2]) maps 00=5, 01=10, 10=20, 11=40 ticks. When the cycle time exceeds the overload time, a relax phase follows the overload phase directly. It lasts cycle minus overload ticks, with relax status (bit 7) at 1.
- R4: When the overload time is equal to or longer than the cycle time, the sequencer goes from overload straight to idle with no relax phase.
- R5: Bit 4 enables triggering on the current-overshoot flag and bit 5 enables triggering on the voltage-undershoot flag. A flag whose enable is 0 has no effect. A qualified trigger starts overload only on a tick edge.
- R6: When relax completes, the sequencer goes to idle, never straight to overload. Another overload needs a trigger present at a later tick.
- R7: A write with bit 6 at 0 during overload ends overload at that write's clock edge. A write with bit 6 at 1 has no effect on the phase.
- R8: A write with bit 7 at 0 during relax ends relax at that write's clock edge. A write with bit 7 at 1 has no effect.
- R9: When both enables are 0, the sequencer is idle with both status bits 0 from the next clock edge onward.
- R10: While the adapter-present input is 0, the sequencer is idle and both enables read 0. Writes to the enables are ignored during that time.
- R11: The read word reflects written codes and enables in bits [5:0], and the live overload and relax status in bits 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| i_over_flag | input | 1 | Input current overshoot comparator (asynchronous) |
| v_under_flag | input | 1 | System voltage undershoot comparator (asynchronous) |
| adapter_ok | input | 1 | Adapter present |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write word |
| cfg_rdata | output | 8 | Configuration and status read word |
| ilim_hi_sel | output | 1 | 1 selects the higher (overload) current limit |
| ovld_stat | output | 1 | Overload phase active |
| relax_stat | output | 1 | Relax phase active |

## Verification
A comparator flag reaches the trigger logic after two synchronizer edges. The phase then changes at the first tick edge after that, so the bench holds flags for four cycles before pulsing a tick. Phase changes caused by ticks, status-clearing writes and adapter removal appear right after the edge that samples them. The effect of clearing both enables appears one edge after the write, because the enables are registered first. The bench therefore samples one nanosecond after the edge that is due, or after the following edge in the enable-clear case. The sweep covers every pair of timing codes with each trigger source and compares the phase after every tick against a phase computed from the tick count.

// File: rtl/surge_pkg.sv
package surge_pkg;
  localparam int CODE_W = 2;
  localparam int MS_W   = 6;
  localparam int WORD_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_OVLD  = 2'd1,
    PH_RELAX = 2'd2
  } phase_e;

  // read/write word layout, MSB first
  typedef struct packed {
    logic              relax_stat;
    logic              ovld_stat;
    logic              en_under;
    logic              en_over;
    logic [CODE_W-1:0] cyc_code;
    logic [CODE_W-1:0] ovl_code;
  } cfg_word_t;

  function automatic logic [MS_W-1:0] ovl_ticks(input logic [CODE_W-1:0] c);
    case (c)
      2'd0:    ovl_ticks = MS_W'(1);
      2'd1:    ovl_ticks = MS_W'(2);
      2'd2:    ovl_ticks = MS_W'(10);
      default: ovl_ticks = MS_W'(20);
    endcase
  endfunction

  function automatic logic [MS_W-1:0] cyc_ticks(input logic [CODE_W-1:0] c);
    case (c)
      2'd0:    cyc_ticks = MS_W'(5);
      2'd1:    cyc_ticks = MS_W'(10);
      2'd2:    cyc_ticks = MS_W'(20);
      default: cyc_ticks = MS_W'(40);
    endcase
  endfunction
endpackage

// File: rtl/surge_sync.sv
module surge_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[s] <= '0;
        else        st[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[s] <= '0;
        else        st[s] <= st[s-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/surge_cfg_regs.sv
module surge_cfg_regs
  import surge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adapter_ok,
  input  logic              cfg_wr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              ovld_on,
  input  logic              relax_on,
  output logic [CODE_W-1:0] ovl_code,
  output logic [CODE_W-1:0] cyc_code,
  output logic              en_over,
  output logic              en_under,
  output logic              clr_ovld,
  output logic              clr_relax,
  output logic [WORD_W-1:0] cfg_rdata
);
  cfg_word_t wr_w, rd_w;

  assign wr_w = cfg_word_t'(cfg_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovl_code <= 2'b00;
      cyc_code <= 2'b10;
      en_over  <= 1'b0;
      en_under <= 1'b0;
    end else begin
      if (cfg_wr) begin
        ovl_code <= wr_w.ovl_code;
        cyc_code <= wr_w.cyc_code;
      end
      if (!adapter_ok) begin
        en_over  <= 1'b0;
        en_under <= 1'b0;
      end else if (cfg_wr) begin
        en_over  <= wr_w.en_over;
        en_under <= wr_w.en_under;
      end
    end
  end

  // status bits are write-0-to-exit; a 1 written is no request
  assign clr_ovld  = cfg_wr && !wr_w.ovld_stat;
  assign clr_relax = cfg_wr && !wr_w.relax_stat;

  always_comb begin
    rd_w.relax_stat = relax_on;
    rd_w.ovld_stat  = ovld_on;
    rd_w.en_under   = en_under;
    rd_w.en_over    = en_over;
    rd_w.cyc_code   = cyc_code;
    rd_w.ovl_code   = ovl_code;
  end

  assign cfg_rdata = rd_w;
endmodule

// File: rtl/surge_trig_qual.sv
module surge_trig_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic i_over_flag,
  input  logic v_under_flag,
  input  logic en_over,
  input  logic en_under,
  output logic trig,
  output logic mode_en
);
  logic [1:0] flags_s;

  surge_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({v_under_flag, i_over_flag}),
    .q     (flags_s)
  );

  assign trig    = (en_over && flags_s[0]) || (en_under && flags_s[1]);
  assign mode_en = en_over || en_under;
endmodule

// File: rtl/surge_phase_fsm.sv
module surge_phase_fsm
  import surge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              trig,
  input  logic              mode_en,
  input  logic              adapter_ok,
  input  logic              clr_ovld,
  input  logic              clr_relax,
  input  logic [CODE_W-1:0] ovl_code,
  input  logic [CODE_W-1:0] cyc_code,
  output phase_e            phase
);
  logic [MS_W-1:0] cnt;
  logic [MS_W-1:0] ov_len, cy_len, rlx_len;

  assign ov_len  = ovl_ticks(ovl_code);
  assign cy_len  = cyc_ticks(cyc_code);
  assign rlx_len = (cy_len > ov_len) ? (cy_len - ov_len) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (!adapter_ok || !mode_en) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (ms_tick && trig) begin
            phase <= PH_OVLD;
            cnt   <= ov_len;
          end
        end
        PH_OVLD: begin
          if (clr_ovld) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else if (ms_tick) begin
            if (cnt <= MS_W'(1)) begin
              if (rlx_len != '0) begin
                phase <= PH_RELAX;
                cnt   <= rlx_len;
              end else begin
                phase <= PH_IDLE;
                cnt   <= '0;
              end
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        PH_RELAX: begin
          if (clr_relax) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else if (ms_tick) begin
            if (cnt <= MS_W'(1)) begin
              phase <= PH_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/surge_cycle_ctrl.sv
module surge_cycle_ctrl
  import surge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       i_over_flag,
  input  logic       v_under_flag,
  input  logic       adapter_ok,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic       ilim_hi_sel,
  output logic       ovld_stat,
  output logic       relax_stat
);
  logic [CODE_W-1:0] ovl_code, cyc_code;
  logic              en_over, en_under, clr_ovld, clr_relax;
  logic              trig, mode_en;
  phase_e            phase;

  surge_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .adapter_ok(adapter_ok),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .ovld_on   (ovld_stat),
    .relax_on  (relax_stat),
    .ovl_code  (ovl_code),
    .cyc_code  (cyc_code),
    .en_over   (en_over),
    .en_under  (en_under),
    .clr_ovld  (clr_ovld),
    .clr_relax (clr_relax),
    .cfg_rdata (cfg_rdata)
  );

  surge_trig_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
    .clk         (clk),
    .rst_n       (rst_n),
    .i_over_flag (i_over_flag),
    .v_under_flag(v_under_flag),
    .en_over     (en_over),
    .en_under    (en_under),
    .trig        (trig),
    .mode_en     (mode_en)
  );

  surge_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .trig      (trig),
    .mode_en   (mode_en),
    .adapter_ok(adapter_ok),
    .clr_ovld  (clr_ovld),
    .clr_relax (clr_relax),
    .ovl_code  (ovl_code),
    .cyc_code  (cyc_code),
    .phase     (phase)
  );

  assign ovld_stat   = (phase == PH_OVLD);
  assign relax_stat  = (phase == PH_RELAX);
  assign ilim_hi_sel = (phase == PH_OVLD);
endmodule

// File: rtl/surge_cycle_chk.sv
module surge_cycle_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ms_tick,
  input logic       adapter_ok,
  input logic       cfg_wr,
  input logic [1:0] wstat,
  input logic [1:0] ren,
  input logic       ovld_stat,
  input logic       relax_stat
);
  p_enter_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovld_stat) |-> $past(ms_tick));

  p_relax_follows_ovld_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(relax_stat) |-> $past(ovld_stat));

  p_relax_ends_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(relax_stat) |-> !ovld_stat);

  p_clear_ovld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovld_stat && cfg_wr && !wstat[0] && adapter_ok) |=> !ovld_stat);

  p_clear_relax_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (relax_stat && cfg_wr && !wstat[1] && adapter_ok) |=> !relax_stat);

  p_disabled_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ren == 2'b00) |=> (!ovld_stat && !relax_stat));

  p_adapter_gone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !adapter_ok |=> (!ovld_stat && !relax_stat && ren == 2'b00));
endmodule

bind surge_cycle_ctrl surge_cycle_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ms_tick   (ms_tick),
  .adapter_ok(adapter_ok),
  .cfg_wr    (cfg_wr),
  .wstat     (cfg_wdata[7:6]),
  .ren       (cfg_rdata[5:4]),
  .ovld_stat (ovld_stat),
  .relax_stat(relax_stat)
);

// File: tb/sim_surge_cycle_ctrl.sv
`timescale 1ns/1ps
module sim_surge_cycle_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       i_over_flag = 1'b0;
  logic       v_under_flag = 1'b0;
  logic       adapter_ok = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       ilim_hi_sel, ovld_stat, relax_stat;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  surge_cycle_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .i_over_flag(i_over_flag), .v_under_flag(v_under_flag),
    .adapter_ok(adapter_ok), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ilim_hi_sel(ilim_hi_sel),
    .ovld_stat(ovld_stat), .relax_stat(relax_stat)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // {select, overload status, relax status}
  function automatic logic [7:0] outs();
    return {5'b0, ilim_hi_sel, ovld_stat, relax_stat};
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic tick();
    ms_tick = 1'b1;
    step(1);
    ms_tick = 1'b0;
  endtask

  task automatic wr(input int ov, input int cy, input bit eo, input bit eu,
                    input bit so, input bit sr);
    cfg_wdata = {sr, so, eu, eo, 2'(cy), 2'(ov)};
    cfg_wr = 1'b1;
    step(1);
    cfg_wr = 1'b0;
  endtask

  function automatic int ov_ms(input int c);
    return (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 10 : 20;
  endfunction

  function automatic int cy_ms(input int c);
    return 5 << c;
  endfunction

  task automatic enter_ovld(input int ov, input int cy);
    wr(ov, cy, 1'b1, 1'b0, 1'b1, 1'b1);
    i_over_flag = 1'b1;
    step(4);
    tick();
    i_over_flag = 1'b0;
    step(4);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    check("R1 read word", cfg_rdata, 8'h08);
    check("R1 outputs", outs(), 8'h00);

    // R11 layout: ov=2, cy=1, en_under=1 -> 8'h26
    wr(2, 1, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R11 read word", cfg_rdata, 8'h26);

    // R2 R3 R4 R6 sweep of all code pairs and both trigger sources
    for (int src = 0; src < 2; src++) begin
      for (int ov = 0; ov < 4; ov++) begin
        for (int cy = 0; cy < 4; cy++) begin
          int tov, tcy;
          tov = ov_ms(ov);
          tcy = cy_ms(cy);
          wr(ov, cy, src == 0, src == 1, 1'b1, 1'b1);
          if (src == 0) i_over_flag = 1'b1; else v_under_flag = 1'b1;
          step(4);
          for (int n = 1; n <= 45; n++) begin
            logic [7:0] e;
            string r;
            tick();
            if (n == 1) begin
              i_over_flag = 1'b0;
              v_under_flag = 1'b0;
            end
            if (n <= tov) begin e = 8'h06; r = "R2 overload"; end
            else if (tcy > tov && n <= tcy) begin e = 8'h01; r = "R3 relax"; end
            else if (tcy <= tov) begin e = 8'h00; r = "R4 no relax"; end
            else begin e = 8'h00; r = "R6 idle after relax"; end
            check(r, outs(), e);
            step(2);
          end
        end
      end
    end

    // R5 enable gating: only overshoot enabled, undershoot flag raised
    wr(0, 0, 1'b1, 1'b0, 1'b1, 1'b1);
    v_under_flag = 1'b1;
    step(4);
    tick(); tick();
    check("R5 disabled source ignored", outs(), 8'h00);
    v_under_flag = 1'b0;
    i_over_flag = 1'b1;
    step(8);
    check("R5 no entry without tick", outs(), 8'h00);
    tick();
    check("R5 entry on tick", outs(), 8'h06);

    // R6: flag held; ov=1 cy=5 -> idle after tick 6, overload again at tick 7
    for (int n = 2; n <= 6; n++) begin
      step(2);
      tick();
    end
    check("R6 idle after relax with flag held", outs(), 8'h00);
    step(2);
    tick();
    check("R6 re-entry needs tick with trigger", outs(), 8'h06);
    i_over_flag = 1'b0;
    step(4);
    wr(0, 0, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1);

    // R7 overload clear
    enter_ovld(3, 3);
    check("R7 in overload", outs(), 8'h06);
    wr(3, 3, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R7 write 1 no effect", outs(), 8'h06);
    wr(3, 3, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R7 write 0 exits overload", outs(), 8'h00);
    step(2);
    check("R7 stays idle", outs(), 8'h00);

    // R8 relax clear: ov=1 cy=40
    enter_ovld(0, 3);
    tick();
    check("R8 in relax", outs(), 8'h01);
    wr(0, 3, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R8 overload clear ignored in relax", outs(), 8'h01);
    wr(0, 3, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R8 write 0 exits relax", outs(), 8'h00);

    // R9 both enables cleared
    enter_ovld(3, 3);
    wr(3, 3, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1);
    check("R9 idle after disable", outs(), 8'h00);
    check("R9 enables read 0", {6'b0, cfg_rdata[5:4]}, 8'h00);

    // R10 adapter removal
    enter_ovld(3, 3);
    adapter_ok = 1'b0;
    step(1);
    check("R10 idle on removal", outs(), 8'h00);
    check("R10 enables cleared", {6'b0, cfg_rdata[5:4]}, 8'h00);
    wr(3, 3, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R10 enable write ignored", {6'b0, cfg_rdata[5:4]}, 8'h00);
    i_over_flag = 1'b1;
    step(4);
    tick();
    check("R10 no entry while absent", outs(), 8'h00);
    i_over_flag = 1'b0;
    adapter_ok = 1'b1;
    step(1);
    wr(3, 3, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R10 enables writable again", {6'b0, cfg_rdata[5:4]}, 8'h03);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule